// File: doc/BRIEF.md
# ChaCha Single-Step Execution Unit

This block is a 64-bit execution unit for a processor pipeline that adds four custom instructions for the ChaCha stream cipher. Each operand register holds two packed 32-bit state words. Each instruction does one 32-bit addition followed by one exclusive-or and a left rotation. Software builds a full quarter round by issuing the four instructions in sequence.

Every instruction uses the same adder and the same xor-rotate stage. The low two bits of funct7 decide three things: which words feed the adder, which word is mixed into the sum, and how far the mixed value is rotated. The "ad" pair uses rotations of 16 and 8 and produces the new a and d words. The "bc" pair uses rotations of 12 and 7 and produces the new b and c words. The result is registered, so it appears one clock after the instruction is presented, together with a valid strobe. An encoding outside the group raises an unsupported flag and returns zero.

Top module: `chacha_step_unit`

## Requirements
- R1: While rst is high, and in the cycle after it, out_valid, out_unsup and out_result are all zero.
- R2: out_valid is high in exactly the cycles that follow a cycle with in_valid high. The result of an instruction appears one clock after it is presented, and instructions may be issued on consecutive cycles.
- R3: Encoding opcode 7'b0001011, funct3 3'd7 and funct7 7'b0010000 returns {s, rotl(s ^ src1[31:0], 16)}, where s = src1[63:32] + src2[63:32] modulo 2^32.
- R4: With funct7 7'b0010010 and the same opcode and funct3, the result is formed as in R3 but with a rotation of 8.
- R5: With funct7 7'b0010001, the result is {rotl(t ^ src2[63:32], 12), t}, where t = src2[31:0] + src1[31:0] modulo 2^32.
- R6: With funct7 7'b0010011, the result is formed as in R5 but with a rotation of 7.
- R7: A valid instruction whose funct7 is outside 7'b00100xx gives out_unsup high and out_result zero in the result cycle.
- R8: A valid instruction whose opcode is not 7'b0001011, or whose funct3 is not 3'd7, is flagged unsupported whatever its funct7 is.
- R9: In a cycle where out_valid is low, out_result is zero and out_unsup is low, whatever the operands are.
- R10: Issuing ad0, bc0, ad1 and bc1 in that order, with each result fed back as the operand for the next step ({a,d} in src1, {b,c} in src2), produces the words of a complete ChaCha quarter round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| opcode | input | 7 | Major opcode field of the instruction |
| funct3 | input | 3 | funct3 field |
| funct7 | input | 7 | funct7 field; the low two bits select the step |
| src1 | input | 64 | First operand, {a, d} |
| src2 | input | 64 | Second operand, {b, c} |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_result | output | 64 | Packed result words |
| out_unsup | output | 1 | The instruction in the result cycle was not recognised |

## Verification
Two things can fall in the same clock: a result is captured while the next instruction is decoded, and a supported step can directly follow an unsupported encoding or the reverse. The bench issues long back-to-back runs that mix the four steps with random funct7, opcode and funct3 values, so an unsupported flag or a zeroed result sits right next to a live result. Each result cycle is judged against an independently computed expected word and flag, and this would expose any control state leaking from one instruction into the next. Idle gaps are placed between the runs and checked for a quiet output.

// File: rtl/chstep_pkg.sv
package chstep_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned XLEN    = 2 * WORD_W;
    localparam int unsigned SHAMT_W = $clog2(WORD_W);

    localparam logic [6:0] OPC_CUSTOM0 = 7'b0001011;
    localparam logic [2:0] F3_STEP     = 3'd7;
    localparam logic [4:0] F7_GROUP    = 5'b00100;

    localparam logic [SHAMT_W-1:0] ROT_AD_FIRST  = SHAMT_W'(16);
    localparam logic [SHAMT_W-1:0] ROT_AD_SECOND = SHAMT_W'(8);
    localparam logic [SHAMT_W-1:0] ROT_BC_FIRST  = SHAMT_W'(12);
    localparam logic [SHAMT_W-1:0] ROT_BC_SECOND = SHAMT_W'(7);

    typedef enum logic [1:0] {
        STEP_AD0 = 2'b00,
        STEP_BC0 = 2'b01,
        STEP_AD1 = 2'b10,
        STEP_BC1 = 2'b11
    } step_sel_e;

    typedef struct packed {
        logic               supported;
        logic               is_bc;
        logic [SHAMT_W-1:0] rot;
    } step_ctl_t;

    typedef struct packed {
        logic [WORD_W-1:0] add_x;
        logic [WORD_W-1:0] add_y;
        logic [WORD_W-1:0] mix;
    } step_opnd_t;

    typedef struct packed {
        logic [WORD_W-1:0] sum;
        logic [WORD_W-1:0] mixed;
    } step_raw_t;

    function automatic logic [WORD_W-1:0] rotl_word(input logic [WORD_W-1:0] x,
                                                    input logic [SHAMT_W-1:0] r);
        logic [XLEN-1:0] twice;
        twice = {x, x} << r;
        return twice[XLEN-1:WORD_W];
    endfunction

endpackage

// File: rtl/chstep_decode.sv
module chstep_decode
    import chstep_pkg::*;
(
    input  logic [6:0] opcode,
    input  logic [2:0] funct3,
    input  logic [6:0] funct7,
    output step_ctl_t  ctl
);
    step_sel_e sel;

    always_comb begin
        sel           = step_sel_e'(funct7[1:0]);
        ctl.supported = (opcode == OPC_CUSTOM0) && (funct3 == F3_STEP)
                        && (funct7[6:2] == F7_GROUP);
        ctl.is_bc     = funct7[0];
        unique case (sel)
            STEP_AD0: ctl.rot = ROT_AD_FIRST;
            STEP_BC0: ctl.rot = ROT_BC_FIRST;
            STEP_AD1: ctl.rot = ROT_AD_SECOND;
            STEP_BC1: ctl.rot = ROT_BC_SECOND;
            default:  ctl.rot = ROT_AD_FIRST;
        endcase
    end
endmodule

// File: rtl/chstep_steer.sv
module chstep_steer
    import chstep_pkg::*;
(
    input  step_ctl_t         ctl,
    input  logic [XLEN-1:0]   src1,
    input  logic [XLEN-1:0]   src2,
    output step_opnd_t        opnd
);
    logic [WORD_W-1:0] w_a, w_d, w_b, w_c;

    always_comb begin
        w_a = src1[XLEN-1:WORD_W];
        w_d = src1[WORD_W-1:0];
        w_b = src2[XLEN-1:WORD_W];
        w_c = src2[WORD_W-1:0];
        if (ctl.is_bc) begin
            opnd.add_x = w_c;
            opnd.add_y = w_d;
            opnd.mix   = w_b;
        end else begin
            opnd.add_x = w_a;
            opnd.add_y = w_b;
            opnd.mix   = w_d;
        end
    end
endmodule

// File: rtl/chstep_core.sv
module chstep_core
    import chstep_pkg::*;
(
    input  step_opnd_t         opnd,
    input  logic [SHAMT_W-1:0] rot,
    output step_raw_t          raw
);
    always_comb begin
        raw.sum   = opnd.add_x + opnd.add_y;
        raw.mixed = rotl_word(raw.sum ^ opnd.mix, rot);
    end
endmodule

// File: rtl/chacha_step_unit.sv
module chacha_step_unit
    import chstep_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [6:0]      opcode,
    input  logic [2:0]      funct3,
    input  logic [6:0]      funct7,
    input  logic [63:0]     src1,
    input  logic [63:0]     src2,
    output logic            out_valid,
    output logic [63:0]     out_result,
    output logic            out_unsup
);
    step_ctl_t       ctl;
    step_opnd_t      opnd;
    step_raw_t       raw;
    logic [XLEN-1:0] packed_res;

    chstep_decode u_decode (.opcode(opcode), .funct3(funct3), .funct7(funct7), .ctl(ctl));
    chstep_steer  u_steer  (.ctl(ctl), .src1(src1), .src2(src2), .opnd(opnd));
    chstep_core   u_core   (.opnd(opnd), .rot(ctl.rot), .raw(raw));

    always_comb begin
        if (!ctl.supported)
            packed_res = '0;
        else if (ctl.is_bc)
            packed_res = {raw.mixed, raw.sum};
        else
            packed_res = {raw.sum, raw.mixed};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_unsup  <= 1'b0;
        end else begin
            out_valid  <= in_valid;
            out_result <= in_valid ? packed_res : '0;
            out_unsup  <= in_valid && !ctl.supported;
        end
    end

    assert_issue_valid_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_unsup_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !ctl.supported) |=> (out_unsup && out_result == '0));
    assert_bad_major_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (opcode != OPC_CUSTOM0 || funct3 != F3_STEP)) |=> out_unsup);
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_result == '0 && !out_unsup));
endmodule

// File: tb/chacha_step_unit_test.sv
module chacha_step_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [6:0]  opcode = '0;
    logic [2:0]  funct3 = '0;
    logic [6:0]  funct7 = '0;
    logic [63:0] src1 = '0;
    logic [63:0] src2 = '0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_unsup;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [6:0] OPC = 7'b0001011;

    always #5 clk = ~clk;

    chacha_step_unit uut (.clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
        .funct3(funct3), .funct7(funct7), .src1(src1), .src2(src2),
        .out_valid(out_valid), .out_result(out_result), .out_unsup(out_unsup));

    function automatic logic [31:0] rl(input logic [31:0] x, input int r);
        return (x << r) | (x >> (32 - r));
    endfunction

    function automatic logic [63:0] ref_step(input logic [6:0] f7, input logic [6:0] op,
            input logic [2:0] f3, input logic [63:0] s1, input logic [63:0] s2,
            output bit unsup);
        logic [31:0] s;
        unsup = !(op == OPC && f3 == 3'd7 && f7[6:2] == 5'b00100);
        if (unsup) return 64'd0;
        case (f7[1:0])
            2'b00: begin s = s1[63:32] + s2[63:32]; return {s, rl(s ^ s1[31:0], 16)}; end
            2'b10: begin s = s1[63:32] + s2[63:32]; return {s, rl(s ^ s1[31:0], 8)}; end
            2'b01: begin s = s2[31:0] + s1[31:0];   return {rl(s ^ s2[63:32], 12), s}; end
            default: begin s = s2[31:0] + s1[31:0]; return {rl(s ^ s2[63:32], 7), s}; end
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one instruction at a falling edge, check its result at the next
    task automatic issue(input logic [6:0] f7, input logic [6:0] op, input logic [2:0] f3,
                         input logic [63:0] s1, input logic [63:0] s2, input string req,
                         output logic [63:0] got);
        bit eu;
        logic [63:0] er;
        @(negedge clk);
        in_valid = 1'b1; funct7 = f7; opcode = op; funct3 = f3; src1 = s1; src2 = s2;
        er = ref_step(f7, op, f3, s1, s2, eu);
        @(negedge clk);
        got = out_result;
        check(out_valid == 1'b1, {req, " R2 valid"}, {63'd0, out_valid}, 64'd1);
        check(out_result == er, req, out_result, er);
        check(out_unsup == eu, {req, " flag"}, {63'd0, out_unsup}, {63'd0, eu});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; src1 = {$urandom, $urandom}; src2 = {$urandom, $urandom};
            funct7 = 7'b0010000; opcode = OPC; funct3 = 3'd7;
            @(negedge clk);
            check(out_valid == 1'b0 && out_result == 64'd0 && out_unsup == 1'b0,
                  "R9 idle quiet", out_result, 64'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] r, ad, bc;
        logic [31:0] qa, qb, qc, qd;
        void'($urandom(32'h0c4a5eed));
        repeat (3) @(negedge clk);
        check(out_valid == 0 && out_result == 0 && out_unsup == 0, "R1 in reset",
              out_result, 64'd0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check(out_valid == 0 && out_result == 0 && out_unsup == 0, "R1 after reset",
              out_result, 64'd0);

        // directed: each step with carry-out and wrap patterns
        issue(7'b0010000, OPC, 3'd7, 64'hFFFFFFFF_0000FFFF, 64'h00000001_12345678, "R3 ad0", r);
        issue(7'b0010010, OPC, 3'd7, 64'h80000000_FFFFFFFF, 64'h80000000_0, "R4 ad1", r);
        issue(7'b0010001, OPC, 3'd7, 64'h0_FFFFFFFF, 64'hA5A5A5A5_00000001, "R5 bc0", r);
        issue(7'b0010011, OPC, 3'd7, 64'h0_12345678, 64'hDEADBEEF_87654321, "R6 bc1", r);
        issue(7'b0110000, OPC, 3'd7, 64'h1, 64'h2, "R7 bad funct7", r);
        issue(7'b0010000, 7'b0110011, 3'd7, 64'h1, 64'h2, "R8 bad opcode", r);
        issue(7'b0010001, OPC, 3'd0, 64'h1, 64'h2, "R8 bad funct3", r);
        idle(2);

        // R10: quarter round chain against a known vector
        ad = {32'h11111111, 32'h01234567};
        bc = {32'h01020304, 32'h9b8d6f43};
        issue(7'b0010000, OPC, 3'd7, ad, bc, "R10 ad0", ad);
        issue(7'b0010001, OPC, 3'd7, ad, bc, "R10 bc0", bc);
        issue(7'b0010010, OPC, 3'd7, ad, bc, "R10 ad1", ad);
        issue(7'b0010011, OPC, 3'd7, ad, bc, "R10 bc1", bc);
        check(ad == {32'hea2a92f4, 32'h5881c4bb} && bc == {32'hcb1cf8ce, 32'h4581472e},
              "R10 quarter round", {ad[63:32], bc[63:32]}, {32'hea2a92f4, 32'hcb1cf8ce});

        // R10: random states against a plain quarter-round model
        for (int k = 0; k < 20; k++) begin
            qa = $urandom; qb = $urandom; qc = $urandom; qd = $urandom;
            ad = {qa, qd}; bc = {qb, qc};
            issue(7'b0010000, OPC, 3'd7, ad, bc, "R10 ad0 rnd", ad);
            issue(7'b0010001, OPC, 3'd7, ad, bc, "R10 bc0 rnd", bc);
            issue(7'b0010010, OPC, 3'd7, ad, bc, "R10 ad1 rnd", ad);
            issue(7'b0010011, OPC, 3'd7, ad, bc, "R10 bc1 rnd", bc);
            qa += qb; qd = rl(qd ^ qa, 16); qc += qd; qb = rl(qb ^ qc, 12);
            qa += qb; qd = rl(qd ^ qa, 8);  qc += qd; qb = rl(qb ^ qc, 7);
            check(ad == {qa, qd} && bc == {qb, qc}, "R10 random round",
                  {ad[63:32], bc[63:32]}, {qa, qb});
        end

        // mixed back-to-back: R3..R8 with unsupported encodings interleaved
        for (int k = 0; k < 400; k++) begin
            logic [6:0] f7, op;
            logic [2:0] f3;
            f7 = {5'b00100, 2'($urandom)};
            op = OPC; f3 = 3'd7;
            if ($urandom % 5 == 0) f7 = 7'($urandom);
            if ($urandom % 8 == 0) op = 7'($urandom);
            if ($urandom % 8 == 0) f3 = 3'($urandom);
            issue(f7, op, f3, {$urandom, $urandom}, {$urandom, $urandom}, "R3-R8 mix", r);
            if ($urandom % 50 == 0) idle(1);
        end
        idle(2);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule